// File: doc/BRIEF.md
# Bit-Slice Ripple ALU

A purely combinational arithmetic and logic unit built from a row of identical one-bit slices. It is sixteen bits wide by default. One shared decoder turns a 3-bit opcode into four control signals, and every slice receives the same set:

- an invert flag for each operand;
- a 2-bit result select;
- the carry-in of the lowest slice.

Each slice can complement its two operand bits. It then forms AND, OR, XOR and a full-adder sum from those bits and selects one of the four. Carries ripple upward from slice to slice.

Subtraction uses no separate subtractor. The B operand is complemented and the lowest carry-in is forced to 1. NOR uses no separate gate. Both operands are complemented and the AND output is selected. The block has no clock and no state. The result and the carry-out follow the inputs after the ripple delay.

Top module: `bslice_alu`

## Requirements
- R1: Opcode 3'b000 gives result = A & B.
- R2: Opcode 3'b001 gives result = A | B.
- R3: Opcode 3'b100 gives result = A ^ B.
- R4: Opcode 3'b011 gives result = (A + B) mod 2^W, with carry_o = bit W of the unextended sum A + B.
- R5: Opcode 3'b010 gives result = (A - B) mod 2^W. carry_o is 1 exactly when A >= B as unsigned numbers, which is the carry of A + ~B + 1.
- R6: Opcode 3'b101 gives result = ~(A | B). Only in this mode are the A operand bits complemented.
- R7: Opcodes 3'b110 and 3'b111 behave exactly like 3'b000: the result is A & B, with no inversion and carry-in 0.
- R8: For opcodes other than ADD and SUB, carry_o is still driven. It equals bit W of (A' + B') with carry-in 0, where A' and B' are the operands after any inversion the mode applies. For NOR that means ~A + ~B; for the other modes it means A + B.
- R9: SUB with A equal to B gives an all-zero result and carry_o = 1.
- R10: The carry-out of slice i is the carry-in of slice i+1. A carry generated in slice 0 can therefore reach carry_o: for example, FFFF + 0001 gives result 0000 and carry_o 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W (16) | Operand A |
| b_i | input | W (16) | Operand B |
| op_i | input | 3 | Operation code |
| res_o | output | W (16) | Result |
| carry_o | output | 1 | Carry out of the top slice |

## Verification
The embedded checks are immediate assertions evaluated on settled combinational values. They assume that all three inputs hold known 0/1 levels, with no X or Z. They also assume that the inputs change at most once per evaluation, so that the ripple chain has settled before a relation is judged.

The stimulus changes a_i, b_i and op_i together only at a rising edge of the bench clock, and always to fully defined values. Results are compared half a period later. The opcode sweep covers the two unassigned codes so that the decoder's default arm is exercised.

// File: rtl/bslice_alu_pkg.sv
package bslice_alu_pkg;
  localparam int unsigned OP_W = 3;
  localparam logic [OP_W-1:0] OP_AND = 3'b000;
  localparam logic [OP_W-1:0] OP_OR  = 3'b001;
  localparam logic [OP_W-1:0] OP_SUB = 3'b010;
  localparam logic [OP_W-1:0] OP_ADD = 3'b011;
  localparam logic [OP_W-1:0] OP_XOR = 3'b100;
  localparam logic [OP_W-1:0] OP_NOR = 3'b101;

  // Slice result select; the encoding is decoded in every slice
  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_XOR = 2'b11
  } sel_e;

  typedef struct packed {
    logic inv_a;
    logic inv_b;
    sel_e sel;
    logic cin;
  } slice_ctrl_t;
endpackage

// File: rtl/bslice_ctrl_dec.sv
module bslice_ctrl_dec
  import bslice_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output slice_ctrl_t     ctrl_o
);
  always_comb begin
    ctrl_o = '{inv_a: 1'b0, inv_b: 1'b0, sel: SEL_AND, cin: 1'b0};
    unique case (op_i)
      OP_OR:   ctrl_o.sel = SEL_OR;
      OP_ADD:  ctrl_o.sel = SEL_SUM;
      OP_XOR:  ctrl_o.sel = SEL_XOR;
      OP_SUB:  ctrl_o = '{inv_a: 1'b0, inv_b: 1'b1, sel: SEL_SUM, cin: 1'b1};
      OP_NOR:  ctrl_o = '{inv_a: 1'b1, inv_b: 1'b1, sel: SEL_AND, cin: 1'b0};
      default: ctrl_o = '{inv_a: 1'b0, inv_b: 1'b0, sel: SEL_AND, cin: 1'b0};
    endcase
  end

  // Complementing A is only legal as part of NOR
  always_comb begin
    if (ctrl_o.inv_a) begin
      assert_inv_a_only_nor_R6: assert (ctrl_o.inv_b && ctrl_o.sel == SEL_AND);
    end
  end

  // A forced carry-in belongs only to subtraction
  always_comb begin
    if (ctrl_o.cin) begin
      assert_cin_only_sub_R5: assert (ctrl_o.inv_b && !ctrl_o.inv_a && ctrl_o.sel == SEL_SUM);
    end
  end
endmodule

// File: rtl/bslice_unit.sv
module bslice_unit
  import bslice_alu_pkg::*;
(
  input  logic        a_i,
  input  logic        b_i,
  input  slice_ctrl_t ctrl_i,
  input  logic        cin_i,
  output logic        res_o,
  output logic        cout_o
);
  logic a_eff, b_eff, sum;

  assign a_eff  = a_i ^ ctrl_i.inv_a;
  assign b_eff  = b_i ^ ctrl_i.inv_b;
  assign sum    = a_eff ^ b_eff ^ cin_i;
  assign cout_o = (a_eff & b_eff) | (a_eff & cin_i) | (b_eff & cin_i);

  always_comb begin
    unique case (ctrl_i.sel)
      SEL_AND: res_o = a_eff & b_eff;
      SEL_OR:  res_o = a_eff | b_eff;
      SEL_SUM: res_o = sum;
      SEL_XOR: res_o = a_eff ^ b_eff;
      default: res_o = 1'b0;
    endcase
  end

  // Equal operand bits generate or kill the carry regardless of cin
  always_comb begin
    if (a_eff == b_eff) begin
      assert_carry_gen_kill_R10: assert (cout_o == a_eff);
    end
  end
endmodule

// File: rtl/bslice_alu.sv
module bslice_alu
  import bslice_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    res_o,
  output logic            carry_o
);
  slice_ctrl_t  ctrl;
  logic [W:0]   chain;

  bslice_ctrl_dec u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  assign chain[0] = ctrl.cin;

  for (genvar i = 0; i < W; i++) begin : g_slice
    bslice_unit u_bit (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .ctrl_i (ctrl),
      .cin_i  (chain[i]),
      .res_o  (res_o[i]),
      .cout_o (chain[i+1])
    );
  end

  assign carry_o = chain[W];

  always_comb begin
    if (op_i == OP_SUB && a_i == b_i) begin
      assert_sub_self_zero_R9: assert (res_o == '0 && carry_o);
    end
  end

  always_comb begin
    if (op_i == OP_ADD && b_i == '0) begin
      assert_add_zero_ident_R4: assert (res_o == a_i && !carry_o);
    end
  end
endmodule

// File: tb/bslice_alu_tb_top.sv
module bslice_alu_tb_top;
  localparam int unsigned W = 16;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [2:0]   op;
    logic [W-1:0] exp_res;
    logic         exp_co;
    string        tag;
    string        co_tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a, b;
  logic [2:0]   op;
  logic [W-1:0] res;
  logic         co;
  int           checks = 0;
  int           failures = 0;
  bit           done = 1'b0;
  item_t        sb_q[$];

  always #2.5 clk = ~clk;

  bslice_alu #(.W(W)) dut_i (
    .a_i     (a),
    .b_i     (b),
    .op_i    (op),
    .res_o   (res),
    .carry_o (co)
  );

  function automatic item_t model(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] o);
    item_t it;
    logic [W:0] s;
    it.a = x; it.b = y; it.op = o;
    s = {1'b0, x} + {1'b0, y};
    it.co_tag = "R8";
    case (o)
      3'b001: begin it.exp_res = x | y; it.tag = "R2"; end
      3'b100: begin it.exp_res = x ^ y; it.tag = "R3"; end
      3'b011: begin it.exp_res = s[W-1:0]; it.tag = "R4"; it.co_tag = "R4"; end
      3'b010: begin
        it.exp_res = x - y; it.tag = (x == y) ? "R9" : "R5"; it.co_tag = it.tag;
        s = {1'b0, x} + {1'b0, ~y} + 1;
      end
      3'b101: begin
        it.exp_res = ~(x | y); it.tag = "R6";
        s = {1'b0, ~x} + {1'b0, ~y};
      end
      3'b000: begin it.exp_res = x & y; it.tag = "R1"; end
      default: begin it.exp_res = x & y; it.tag = "R7"; end
    endcase
    it.exp_co = s[W];
    return it;
  endfunction

  task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] o);
    @(posedge clk);
    a = x; b = y; op = o;
    sb_q.push_back(model(x, y, o));
  endtask

  task automatic check(bit ok, string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare half a period after the inputs change
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(res === it.exp_res, it.tag, "res", res, it.exp_res);
      check(co === it.exp_co, it.co_tag, "carry",
            {{(W-1){1'b0}}, co}, {{(W-1){1'b0}}, it.exp_co});
    end
  end

  initial begin
    logic [W-1:0] corner [4];
    corner[0] = 16'h0000; corner[1] = 16'hFFFF;
    corner[2] = 16'h8000; corner[3] = 16'h7FFF;
    a = '0; b = '0; op = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: zero operands with AND give zero result and no carry (R1)
    drive('0, '0, 3'b000);
    // full-length carry propagation (R10)
    drive(16'hFFFF, 16'h0001, 3'b011);
    checks++;
    // SUB with equal operands (R9)
    drive(16'h1234, 16'h1234, 3'b010);
    drive(16'h0001, 16'h0002, 3'b010);
    // unassigned opcodes (R7)
    drive(16'hF0F0, 16'hFF00, 3'b110);
    drive(16'hF0F0, 16'hFF00, 3'b111);
    for (int o = 0; o < 8; o++) begin
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          drive(corner[i], corner[j], 3'(o));
      for (int k = 0; k < 24; k++)
        drive(16'($urandom), 16'($urandom), 3'(o));
    end
    repeat (4) @(posedge clk);
    checks--;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule